// File: doc/BRIEF.md
# Pin Edge Interrupt Unit with Per-Pin Glitch Filtering

This block watches a port of asynchronous general-purpose input pins (32 by default) and raises interrupt requests when they change. Each pin is synchronised, optionally passed through a two-sample glitch filter, and compared with its previous level. The comparison detects either any change, a rising edge only, or a falling edge only, as the pin's two-bit mode selects. A detected event latches a per-pin flag. Flags that are also enabled are ORed into one request line for each group of eight consecutive pins.

Software reaches the block through a small register port. It can write the enable, mode and filter-enable words, clear flags by writing zeros, and read the current synchronised level of every pin. A clock-enable input stops new flags from being set while it is low. The filter acts on the interrupt path only: the pin-value read always shows the unfiltered synchronised level.

Top module: `gpio_irq_unit`

## Requirements
- R1: The pin-value word (address 5, read only) shows each pin's level two clock edges after the pin changes, whatever the filter setting.
- R2: The register addresses are: 0 interrupt enable, 1 mode bit 0, 2 mode bit 1, 3 filter enable, 4 flags, 5 pin value. Addresses 0 to 3 read back what was written, and addresses 6 and 7 read zero.
- R3: The two mode bits of pin i are bit i of address 2 (high) and bit i of address 1 (low). Code 01 flags rising edges only, 10 flags falling edges only, and 00 and 11 flag any change.
- R4: A write to address 4 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R5: If a pin event and a clearing write to the same flag fall on the same clock edge, the flag ends up at 1.
- R6: Flags latch whether or not the pin's enable bit is set. Only a flag whose enable bit is 1 contributes to a request.
- R7: Request output g is high exactly when some pin among 8g to 8g+7 has both its flag and its enable bit at 1.
- R8: While clk_en is low no flag is set. Edge history keeps tracking the pins, so raising clk_en over a steady pin creates no event.
- R9: With a pin's filter enabled, a synchronised pulse lasting one cycle is rejected and a pulse of two cycles is accepted. Pins whose filter is off see every pulse.
- R10: With the filter off, a flag is set on the third rising edge after a pin change. With the filter on, it is set on the fifth.
- R11: After reset, every register, every flag and every request output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Enables flag setting |
| pins_in | input | NPINS | Asynchronous pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NPINS | Register write data |
| reg_rdata | output | NPINS | Register read data (combinational) |
| irq_grp | output | NPINS/8 | One request per eight-pin group |

## Verification
A pin event and a software clear of the same flag can land on the same clock edge. The bench provokes this by changing a pin and then timing a write of zero to the flag register so that the write lands on the edge where the edge detector fires. That edge is the third after the pin change. The flag must read 1 afterwards. A second clearing write with no event must then bring it to 0. A clocked property also checks, on every edge with an event, that the event's flag bits are set on the next cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    RA_ENABLE  = 3'd0,
    RA_MODE_LO = 3'd1,
    RA_MODE_HI = 3'd2,
    RA_FILTER  = 3'd3,
    RA_FLAGS   = 3'd4,
    RA_PINVAL  = 3'd5
  } reg_addr_e;

  // mode: 01 rising, 10 falling, 00/11 any change
  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    case (mode)
      2'b01:   return cur & ~prev;
      2'b10:   return ~cur & prev;
      default: return cur ^ prev;
    endcase
  endfunction

  // next flag value: clear on written zero, set wins
  function automatic logic flag_next(input logic cur, input logic clr_wr, input logic wbit,
                                     input logic set);
    return (clr_wr ? (cur & wbit) : cur) | set;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] fen,
  output logic [W-1:0] lvl,
  output logic [W-1:0] q
);
  logic [W-1:0] samp_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samp_q[i] <= 1'b0;
        lvl[i]    <= 1'b0;
      end else begin
        samp_q[i] <= d[i];
        if (samp_q[i] == d[i]) lvl[i] <= d[i];
      end
    end
    assign q[i] = fen[i] ? lvl[i] : d[i];
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] pin_val,
  output logic [W-1:0] en_q,
  output logic [W-1:0] mode_lo_q,
  output logic [W-1:0] mode_hi_q,
  output logic [W-1:0] fen_q,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] rdata
);
  logic clr_wr;
  assign clr_wr = wr && (addr == RA_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      fen_q     <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        RA_ENABLE:  en_q      <= wdata;
        RA_MODE_LO: mode_lo_q <= wdata;
        RA_MODE_HI: mode_hi_q <= wdata;
        RA_FILTER:  fen_q     <= wdata;
        default:    ;
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flag_next(flags_q[i], clr_wr, wdata[i], evt_set[i]);
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      RA_ENABLE:  rdata = en_q;
      RA_MODE_LO: rdata = mode_lo_q;
      RA_MODE_HI: rdata = mode_hi_q;
      RA_FILTER:  rdata = fen_q;
      RA_FLAGS:   rdata = flags_q;
      RA_PINVAL:  rdata = pin_val;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int GROUP = 8,
  localparam int NGRP = NPINS / GROUP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [NPINS-1:0] pins_in,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic [NGRP-1:0]  irq_grp
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] filt_lvl;
  logic [NPINS-1:0] det_in;
  logic [NPINS-1:0] hist_q;
  logic [NPINS-1:0] evt_hit;
  logic [NPINS-1:0] evt_set;
  logic [NPINS-1:0] irq_en, mode_lo, mode_hi, fen, flags;

  gpio_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_in), .q(pin_sync)
  );

  gpio_glitch_filter #(.W(NPINS)) u_filt (
    .clk(clk), .rst_n(rst_n), .d(pin_sync), .fen(fen), .lvl(filt_lvl), .q(det_in)
  );

  // history tracks every cycle, independent of enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= det_in;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    assign evt_hit[i] = edge_hit({mode_hi[i], mode_lo[i]}, hist_q[i], det_in[i]);
  end
  assign evt_set = evt_hit & {NPINS{clk_en}};

  gpio_irq_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .evt_set(evt_set), .pin_val(pin_sync), .en_q(irq_en), .mode_lo_q(mode_lo),
    .mode_hi_q(mode_hi), .fen_q(fen), .flags_q(flags), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq_grp[g] = |(flags[g*GROUP +: GROUP] & irq_en[g*GROUP +: GROUP]);
  end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int GROUP = 8,
  localparam int NGRP = NPINS / GROUP
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [NPINS-1:0] reg_wdata,
  input logic [NGRP-1:0]  irq_grp,
  input logic [NPINS-1:0] flags,
  input logic [NPINS-1:0] irq_en,
  input logic [NPINS-1:0] evt_hit,
  input logic [NPINS-1:0] pin_sync,
  input logic [NPINS-1:0] filt_lvl
);
  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_FLAGS) |=>
      ((flags & $past(flags & reg_wdata)) == $past(flags & reg_wdata)));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && (evt_hit != '0)) |=> ((flags & $past(evt_hit)) == $past(evt_hit)));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & irq_en) == '0) |-> (irq_grp == '0));

  assert_no_set_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ((flags & ~$past(flags)) == '0));

  assert_filter_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_lvl ^ $past(filt_lvl)) & ($past(pin_sync) ^ $past(pin_sync, 2))) == '0);
endmodule

bind gpio_irq_unit gpio_irq_checker #(.NPINS(NPINS), .GROUP(GROUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_grp(irq_grp), .flags(flags), .irq_en(irq_en),
  .evt_hit(evt_hit), .pin_sync(pin_sync), .filt_lvl(filt_lvl)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  localparam int N = 32;
  localparam int NG = N / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b1;
  logic [N-1:0]  pins = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic [NG-1:0] irq_grp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pins_in(pins), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_grp(irq_grp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] grp_of(input logic [N-1:0] f);
    logic [NG-1:0] r = '0;
    for (int i = 0; i < N; i++) if (f[i]) r[i/8] = 1'b1;
    return r;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, mlo, mhi, expf;
    logic [NG-1:0] expg;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), v);
      check("R11 reset reg", v, '0);
    end
    check("R11 reset irq", {{(N-NG){1'b0}}, irq_grp}, '0);

    // R2 register map and readback
    mlo = '0; mhi = '0;
    for (int p = 0; p < N; p++) begin
      mlo[p] = (p % 4) & 1;
      mhi[p] = ((p % 4) >> 1) & 1;
    end
    wr_reg(3'd1, mlo);
    wr_reg(3'd2, mhi);
    wr_reg(3'd0, '1);
    wr_reg(3'd3, 32'h0000_5a00);
    rd_reg(3'd1, v); check("R2 mode lo", v, mlo);
    rd_reg(3'd2, v); check("R2 mode hi", v, mhi);
    rd_reg(3'd3, v); check("R2 filter", v, 32'h0000_5a00);
    rd_reg(3'd0, v); check("R2 enable", v, '1);
    wr_reg(3'd6, '1);
    rd_reg(3'd6, v); check("R2 unused", v, '0);
    wr_reg(3'd3, '0);

    // R3/R7/R10 sweep every pin with mode p%4, filter off
    for (int p = 0; p < N; p++) begin
      logic rise_ok, fall_ok;
      rise_ok = (p % 4) != 2;
      fall_ok = (p % 4) != 1;
      wr_reg(3'd4, '0);
      pins[p] = 1'b1;
      tick(2);
      rd_reg(3'd4, v); check("R10 not yet", v, '0);
      rd_reg(3'd5, v); check("R1 pinval", v, N'(1) << p);
      tick(1);
      expf = rise_ok ? (N'(1) << p) : '0;
      rd_reg(3'd4, v); check("R3 rise", v, expf);
      expg = grp_of(expf);
      check("R7 group", {{(N-NG){1'b0}}, irq_grp}, {{(N-NG){1'b0}}, expg});
      wr_reg(3'd4, '0);
      pins[p] = 1'b0;
      tick(3);
      expf = fall_ok ? (N'(1) << p) : '0;
      rd_reg(3'd4, v); check("R3 fall", v, expf);
    end
    wr_reg(3'd4, '0);

    // R4 write of ones keeps flags
    pins[3] = 1'b1; pins[20] = 1'b1;
    tick(3);
    wr_reg(3'd4, '1);
    rd_reg(3'd4, v); check("R4 ones keep", v, (N'(1) << 3) | (N'(1) << 20));
    wr_reg(3'd4, ~(N'(1) << 3));
    rd_reg(3'd4, v); check("R4 zero clears", v, N'(1) << 20);
    // R6 enable masks request, flags still latched
    wr_reg(3'd0, ~(N'(1) << 20));
    check("R6 masked irq", {{(N-NG){1'b0}}, irq_grp}, '0);
    rd_reg(3'd4, v); check("R6 flag kept", v, N'(1) << 20);
    wr_reg(3'd0, '1);
    check("R7 group 2", {{(N-NG){1'b0}}, irq_grp}, N'(4));
    pins[3] = 1'b0; pins[20] = 1'b0;
    tick(4);
    wr_reg(3'd4, '0);

    // R5 event and clear on the same edge (pin 0 any change)
    pins[0] = 1'b1;
    tick(2);
    wr_reg(3'd4, '0);
    rd_reg(3'd4, v); check("R5 set wins", v, N'(1));
    wr_reg(3'd4, '0);
    rd_reg(3'd4, v); check("R5 later clear", v, '0);

    // R8 clk_en gating
    clk_en = 1'b0;
    pins[0] = 1'b0;
    tick(5);
    rd_reg(3'd4, v); check("R8 gated", v, '0);
    clk_en = 1'b1;
    tick(3);
    rd_reg(3'd4, v); check("R8 no false edge", v, '0);
    pins[0] = 1'b1;
    tick(3);
    rd_reg(3'd4, v); check("R8 resumed", v, N'(1));
    wr_reg(3'd4, '0);

    // R9 filter: pin 9 filtered rising, pin 5 unfiltered rising
    wr_reg(3'd3, N'(1) << 9);
    tick(4);
    wr_reg(3'd4, '0);
    pins[9] = 1'b1; pins[5] = 1'b1;
    tick(1);
    pins[9] = 1'b0; pins[5] = 1'b0;
    tick(8);
    rd_reg(3'd4, v); check("R9 one-cycle pulse", v, N'(1) << 5);
    wr_reg(3'd4, '0);
    pins[9] = 1'b1;
    tick(2);
    rd_reg(3'd5, v); check("R1 pinval unfiltered", v & (N'(1) << 9), N'(1) << 9);
    pins[9] = 1'b0;
    tick(2);
    rd_reg(3'd4, v); check("R10 filtered not yet", v, '0);
    tick(1);
    rd_reg(3'd4, v); check("R9 two-cycle pulse", v, N'(1) << 9);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule